// File: doc/BRIEF.md
# Binary Time-of-Day Counter Chain

This block keeps the time of day as three plain binary counts: seconds (6 bits), minutes (6 bits) and hours (5 bits). All three registers sit in one system clock domain. A one-cycle enable that arrives once per second advances the seconds count. When the seconds count rolls over, it advances the minutes count. When the minutes count rolls over, it advances the hours count. The counts are presented in parallel on the outputs, so external display or digital-to-analog logic can use them directly.

A level input selects between run and set. In set mode the seconds count is cleared to zero and kept there, and the per-second enable has no effect. Two single-cycle strobes then step the minutes and the hours by hand. Each strobe is merged into the carry path of its counter, so a minute step at 59 carries into the hours exactly as a natural rollover does. Rollover is found by decoding only the high bits of the incremented value. For 60 the decode is bits 5 down to 2 all set. For 24 the decode is bits 4 and 3 both set. Because of this, the wrapped value is never loaded and never reaches the outputs.

Top module: `tod_counter_chain`

## Requirements
- R1: Asserting `rst_n` low clears seconds, minutes and hours to 0 at once. Counting resumes two clock edges after `rst_n` is released.
- R2: In run mode (`hold_set` = 0), a cycle with `tick_1hz` = 1 advances seconds by one, and a cycle with `tick_1hz` = 0 leaves seconds unchanged.
- R3: In run mode, a tick at 59 seconds loads 0 into seconds and advances minutes by one on the same edge.
- R4: A minute advance at 59 minutes loads 0 into minutes and advances hours by one on the same edge.
- R5: An hour advance at 23 hours loads 0 into hours, so a tick at 23:59:59 gives 00:00:00.
- R6: While `hold_set` = 1, seconds is 0 from the next edge on and stays 0, whatever `tick_1hz` does.
- R7: While `hold_set` = 1, each cycle with `min_step` = 1 advances minutes by one.
- R8: A `min_step` at 59 minutes in set mode wraps minutes to 0 and advances hours by one. If `hr_step` is high in that same cycle, hours still advance by only one.
- R9: An `hr_step` in set mode at 23 hours wraps hours to 0 and leaves minutes unchanged.
- R10: In run mode, `min_step` and `hr_step` have no effect on the counts.
- R11: The outputs never exceed 59 seconds, 59 minutes or 23 hours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| hold_set | input | 1 | 1 = set mode (seconds held at 0, strobes accepted), 0 = run |
| min_step | input | 1 | Single-cycle manual minute increment |
| hr_step | input | 1 | Single-cycle manual hour increment |
| sec_o | output | 6 | Seconds count, binary 0..59 |
| min_o | output | 6 | Minutes count, binary 0..59 |
| hr_o | output | 5 | Hours count, binary 0..23 |

## Verification
The assertions check the following on every cycle:
- the legal range of all three counts;
- the seconds clamp in set mode;
- the one-step advance of seconds and of minutes for each cause;
- that minutes hold when no carry or accepted strobe is present;
- the wraps at 59 seconds, at 59 minutes under a strobe, and at 23 hours.

Only the bench scenarios can show the following:
- the full chained rollover from 23:59:59 to midnight after a long run of ticks;
- a minute wrap that coincides with an hour strobe, which must give one hour step and not two;
- the asynchronous clear during counting, followed by the delayed restart.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int SEC_WRAP = 60;
  localparam int MIN_WRAP = 60;
  localparam int HR_WRAP  = 24;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign srst_n = pipe_q[STAGES-1];
endmodule

// File: rtl/tod_wrap_counter.sv
module tod_wrap_counter #(
  parameter int W    = 6,
  parameter int WRAP = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  output logic [W-1:0] cnt_o,
  output logic         carry_o
);
  // Only the bits that are set in the wrap value are decoded; counting from
  // zero, the first incremented value that has all of them set is WRAP.
  localparam logic [W-1:0] DECODE_MASK = W'(WRAP);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] inc_val;
  logic         hit;

  always_comb begin
    inc_val = cnt_q + {{(W-1){1'b0}}, 1'b1};
    hit     = &(inc_val | ~DECODE_MASK);
    carry_o = adv & hit & ~clr;
    cnt_d   = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = hit ? '0 : inc_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tod_set_ctrl.sv
module tod_set_ctrl (
  input  logic hold_set,
  input  logic tick_1hz,
  input  logic min_step,
  input  logic hr_step,
  input  logic sec_carry,
  input  logic min_carry,
  output logic sec_clr,
  output logic sec_adv,
  output logic min_adv,
  output logic hr_adv
);
  always_comb begin
    sec_clr = hold_set;
    sec_adv = tick_1hz & ~hold_set;
    // Manual strobes merge into the carry path; accepted only in set mode.
    min_adv = sec_carry | (hold_set & min_step);
    hr_adv  = min_carry | (hold_set & hr_step);
  end
endmodule

// File: rtl/tod_counter_chain.sv
module tod_counter_chain
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1hz,
  input  logic             hold_set,
  input  logic             min_step,
  input  logic             hr_step,
  output logic [SEC_W-1:0] sec_o,
  output logic [MIN_W-1:0] min_o,
  output logic [HR_W-1:0]  hr_o
);
  logic core_rst_n;
  logic sec_clr, sec_adv, min_adv, hr_adv;
  logic sec_carry, min_carry, day_roll;

  tod_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  tod_set_ctrl u_ctrl (
    .hold_set  (hold_set),
    .tick_1hz  (tick_1hz),
    .min_step  (min_step),
    .hr_step   (hr_step),
    .sec_carry (sec_carry),
    .min_carry (min_carry),
    .sec_clr   (sec_clr),
    .sec_adv   (sec_adv),
    .min_adv   (min_adv),
    .hr_adv    (hr_adv)
  );

  tod_wrap_counter #(.W(SEC_W), .WRAP(SEC_WRAP)) u_sec (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (sec_clr),
    .adv     (sec_adv),
    .cnt_o   (sec_o),
    .carry_o (sec_carry)
  );

  tod_wrap_counter #(.W(MIN_W), .WRAP(MIN_WRAP)) u_min (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (1'b0),
    .adv     (min_adv),
    .cnt_o   (min_o),
    .carry_o (min_carry)
  );

  tod_wrap_counter #(.W(HR_W), .WRAP(HR_WRAP)) u_hr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .clr     (1'b0),
    .adv     (hr_adv),
    .cnt_o   (hr_o),
    .carry_o (day_roll)
  );
endmodule

// File: rtl/tod_chain_checker.sv
module tod_chain_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       hold_set,
  input logic       min_step,
  input logic       hr_step,
  input logic       day_roll,
  input logic [5:0] sec,
  input logic [5:0] mins,
  input logic [4:0] hrs
);
  p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sec < 6'd60) && (mins < 6'd60) && (hrs < 5'd24));

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_set |=> (sec == 6'd0));

  p_sec_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_set && !tick_1hz) |=> $stable(sec));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_set && tick_1hz && sec != 6'd59) |=> (sec == $past(sec) + 6'd1));

  p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_set && tick_1hz && sec == 6'd59) |=>
      (sec == 6'd0) && (mins == (($past(mins) == 6'd59) ? 6'd0 : $past(mins) + 6'd1)));

  p_min_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_set && !(tick_1hz && sec == 6'd59)) |=> $stable(mins));

  p_min_bump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_set && min_step && mins != 6'd59) |=> (mins == $past(mins) + 6'd1));

  p_min_bump_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_set && min_step && mins == 6'd59) |=>
      (mins == 6'd0) && (hrs == (($past(hrs) == 5'd23) ? 5'd0 : $past(hrs) + 5'd1)));

  p_hr_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_set && hr_step && hrs == 5'd23) |=> (hrs == 5'd0));

  p_day_roll_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day_roll |=> (hrs == 5'd0));
endmodule

bind tod_counter_chain tod_chain_checker u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .tick_1hz (tick_1hz),
  .hold_set (hold_set),
  .min_step (min_step),
  .hr_step  (hr_step),
  .day_roll (day_roll),
  .sec      (sec_o),
  .mins     (min_o),
  .hrs      (hr_o)
);

// File: tb/tod_counter_chain_tb.sv
module tod_counter_chain_tb_top;
  localparam time HALF = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       hold_set = 1'b0;
  logic       min_step = 1'b0;
  logic       hr_step = 1'b0;
  logic [5:0] sec_o;
  logic [5:0] min_o;
  logic [4:0] hr_o;

  typedef struct {
    int    s;
    int    m;
    int    h;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  int   ms = 0, mm = 0, mh = 0;
  bit   finished = 1'b0;

  always #HALF clk = ~clk;

  tod_counter_chain dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .hold_set (hold_set),
    .min_step (min_step),
    .hr_step  (hr_step),
    .sec_o    (sec_o),
    .min_o    (min_o),
    .hr_o     (hr_o)
  );

  task automatic compare(input int s, input int m, input int h, input string tag);
    n_vec++;
    if (int'(sec_o) != s || int'(min_o) != m || int'(hr_o) != h) begin
      n_bad++;
      $display("FAIL %s: got %0d:%0d:%0d expected %0d:%0d:%0d",
               tag, hr_o, min_o, sec_o, h, m, s);
    end
  endtask

  // Monitor: sample 5 ns after each rising edge, pop the item for that edge.
  always @(posedge clk) begin
    #5ns;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      compare(e.s, e.m, e.h, e.tag);
    end
  end

  // Driver: one cycle of stimulus plus the expected result from the requirements.
  task automatic step(input logic st, input logic tk, input logic mb,
                      input logic hb, input string tag);
    bit   madv, hadv;
    exp_t e;
    @(negedge clk);
    hold_set = st; tick_1hz = tk; min_step = mb; hr_step = hb;
    madv = 1'b0;
    hadv = 1'b0;
    if (st) begin
      ms = 0;                       // R6
      madv = mb;                    // R7
      hadv = hb;                    // R9
    end else if (tk) begin
      ms++;                         // R2
      if (ms == 60) begin ms = 0; madv = 1'b1; end  // R3
    end
    if (madv) begin
      mm++;
      if (mm == 60) begin mm = 0; hadv = 1'b1; end  // R4, R8
    end
    if (hadv) begin
      mh++;
      if (mh == 24) mh = 0;         // R5
    end
    e.s = ms; e.m = mm; e.h = mh; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    @(negedge clk);
    hold_set = 1'b0; tick_1hz = 1'b0; min_step = 1'b0; hr_step = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2ns;
    compare(0, 0, 0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      step(0, 1, 0, 0, "R2 tick");
      step(0, 0, 0, 0, "R2 idle");
    end
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, "R10 strobes in run");
    step(0, 0, 1, 0, "R10 strobe no tick");
    step(1, 1, 0, 0, "R6 clamp");
    step(1, 1, 0, 0, "R6 tick in set");
    step(1, 0, 0, 0, "R6 hold");

    for (int i = 0; i < 59; i++) step(1, 0, 1, 0, "R7 minute step");
    step(1, 0, 1, 0, "R8 minute wrap");
    for (int i = 0; i < 22; i++) step(1, 0, 0, 1, "R9 hour step");
    step(1, 0, 0, 1, "R9 hour wrap");

    for (int i = 0; i < 59; i++) step(1, 0, 1, 0, "R7 minute step");
    for (int i = 0; i < 23; i++) step(1, 0, 0, 1, "R9 hour step");
    step(1, 0, 1, 1, "R8 wrap with hour step");
    for (int i = 0; i < 59; i++) step(1, 0, 1, 0, "R7 minute step");
    for (int i = 0; i < 23; i++) step(1, 0, 0, 1, "R9 hour step");

    for (int i = 0; i < 59; i++) step(0, 1, 0, 0, "R2 run to 59");
    step(0, 1, 0, 0, "R3 R4 R5 R11 midnight rollover");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R2 after rollover");
    step(0, 0, 0, 0, "R2 idle");

    settle();
    for (int i = 0; i < 7; i++) step(0, 1, 0, 0, "R2 pre-reset");
    settle();
    rst_n = 1'b0;
    #1ns;
    compare(0, 0, 0, "R1 async clear");
    ms = 0; mm = 0; mh = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(0, 1, 0, 0, "R1 restart");
    step(0, 1, 0, 0, "R1 restart");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(2 * HALF * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule